// File: doc/BRIEF.md
# Parallel-Port Handshake Flag Unit

This block sits between a host controller and a 16-bit parallel link to a peer processor. It drives the outgoing halfword and two strobe lines toward the peer: a "ready for input" line and a "transfer done" line. Each of the peer's two request lines passes through a synchronizer into an edge latch. A latch is set by a rising edge, stays set while the request level is held, and is cleared only by a host command. The unit raises an interrupt whenever a latch is set and its enable bit is on.

The host drives a single write port with an address and 16 bits of data. One write loads the control register (strobe levels and interrupt enables) and clears both latches. Two compound commands carry out the usual exchange steps. "Send" presents a halfword and briefly drops the ready line. "Take" acknowledges incoming data by pulsing the done line. Two further addresses clear the latches one at a time. In loopback mode, the outgoing strobes feed the latches in place of the peer's lines, so the driver can be exercised with no peer attached.

Top module: `hs_flag_unit`

## Requirements
- R1: While `rst_n` is low, the unit clears all outputs, the latches, the control state and the link data to zero.
- R2: A write to address 0 loads the control register from `wr_data`. Bit 0 is the ready strobe level and bit 1 is the done strobe level. Bit 4 enables the interrupt for the request-A latch and bit 5 enables the interrupt for the request-B latch. Bits 2 and 3 are not stored and read back as 0. The same write clears both latches. The new values take effect on the next cycle.
- R3: A write to address 1 ("send") clears the request-B latch and places `wr_data` on `link_data` on the next cycle. It also drives `str_ready` low for exactly one cycle and then high, where it stays.
- R4: A write to address 2 ("take") clears the request-A latch and drives `str_done` high for the next single cycle. The stored done level is not changed.
- R5: A write to address 3 clears only the request-B latch, and a write to address 4 clears only the request-A latch.
- R6: Outside loopback, a rising edge on `peer_req_a` (or `peer_req_b`) sets the request-A (or request-B) latch three clock edges after the input rises. A level held high does not set the latch again once it has been cleared.
- R7: In loopback (`loop_mode` high), a rising edge of `str_ready` sets the request-A latch and a rising edge of `str_done` sets the request-B latch, both on the following clock edge. The peer request inputs have no effect.
- R8: `irq` is high exactly when (request-A latch AND bit-4 enable) OR (request-B latch AND bit-5 enable).
- R9: When a latch-setting edge and a clearing write reach the same clock edge, the latch ends up set.
- R10: Reading with `rd_addr` 0 returns the control bits in positions 0, 1, 4 and 5, the request-A latch in bit 6 and the request-B latch in bit 7, with all other bits 0. Reading with `rd_addr` 1 returns `peer_din`. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address / command |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 1 | Host read select |
| rd_data | output | 16 | Host read data |
| loop_mode | input | 1 | Loopback: strobes drive the latches |
| peer_req_a | input | 1 | Peer request A (asynchronous) |
| peer_req_b | input | 1 | Peer request B (asynchronous) |
| peer_din | input | 16 | Halfword presented by the peer |
| link_data | output | 16 | Halfword driven to the peer |
| str_ready | output | 1 | Ready-for-input strobe to the peer |
| str_done | output | 1 | Transfer-done strobe to the peer |
| irq | output | 1 | Interrupt request |

## Verification
The assertion on the restored ready level assumes that no control-register write arrives in the cycle right after a send, since such a write would override that level. The stimulus always leaves idle cycles after every command. The loopback latch check relies on `loop_mode` being steady in the cycle that produces the strobe edge. The bench changes `loop_mode` only while no command is in flight. Peer request levels are held for several cycles, so that each synchronizer sees a clean transition.

// File: rtl/hs_flag_unit.sv
module hs_flag_unit #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int SYNC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          loop_mode,
  input  logic          peer_req_a,
  input  logic          peer_req_b,
  input  logic [DW-1:0] peer_din,
  output logic [DW-1:0] link_data,
  output logic          str_ready,
  output logic          str_done,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = 0, A_SEND = 1, A_TAKE = 2, A_CLR_B = 3, A_CLR_A = 4;

  logic ready_lvl, done_lvl, en_a, en_b, raise_pend, done_pulse;
  logic prev_ready, prev_done, lat_a, lat_b;
  logic [SYNC-1:0] sync_a, sync_b;

  assign str_ready = ready_lvl;
  assign str_done  = done_lvl | done_pulse;

  wire set_a = loop_mode ? (str_ready & ~prev_ready) : (sync_a[SYNC-2] & ~sync_a[SYNC-1]);
  wire set_b = loop_mode ? (str_done & ~prev_done)   : (sync_b[SYNC-2] & ~sync_b[SYNC-1]);
  wire clr_a = wr_en & (wr_addr == A_CTRL || wr_addr == A_TAKE || wr_addr == A_CLR_A);
  wire clr_b = wr_en & (wr_addr == A_CTRL || wr_addr == A_SEND || wr_addr == A_CLR_B);

  assign irq = (lat_a & en_a) | (lat_b & en_b);
  assign rd_data = rd_addr ? peer_din
                           : DW'({lat_b, lat_a, en_b, en_a, 2'b00, done_lvl, ready_lvl});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_lvl  <= 1'b0;
      done_lvl   <= 1'b0;
      en_a       <= 1'b0;
      en_b       <= 1'b0;
      raise_pend <= 1'b0;
      done_pulse <= 1'b0;
      prev_ready <= 1'b0;
      prev_done  <= 1'b0;
      lat_a      <= 1'b0;
      lat_b      <= 1'b0;
      sync_a     <= '0;
      sync_b     <= '0;
      link_data  <= '0;
    end else begin
      prev_ready <= str_ready;
      prev_done  <= str_done;
      sync_a     <= {sync_a[SYNC-2:0], peer_req_a};
      sync_b     <= {sync_b[SYNC-2:0], peer_req_b};
      done_pulse <= 1'b0;
      if (raise_pend) begin
        ready_lvl  <= 1'b1;
        raise_pend <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            ready_lvl  <= wr_data[0];
            done_lvl   <= wr_data[1];
            en_a       <= wr_data[4];
            en_b       <= wr_data[5];
            raise_pend <= 1'b0;
          end
          A_SEND: begin
            link_data  <= wr_data;
            ready_lvl  <= 1'b0;
            raise_pend <= 1'b1;
          end
          A_TAKE:  done_pulse <= 1'b1;
          default: ;
        endcase
      end
      lat_a <= set_a | (lat_a & ~clr_a);
      lat_b <= set_b | (lat_b & ~clr_b);
    end
  end
endmodule

// File: rtl/hs_flag_unit_chk.sv
module hs_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        loop_mode,
  input logic [15:0] link_data,
  input logic        str_ready,
  input logic        str_done,
  input logic        lat_a,
  input logic        lat_b,
  input logic        en_a,
  input logic        en_b,
  input logic        irq
);
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd0 |=> str_ready == $past(wr_data[0]) && en_a == $past(wr_data[4]) && en_b == $past(wr_data[5])); // R2
  AST_SEND_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd1 |=> link_data == $past(wr_data) && !str_ready); // R3
  AST_SEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd1 ##1 !(wr_en && wr_addr == 3'd0) |=> str_ready); // R3
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd2 |=> str_done); // R4
  AST_LOOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode && $rose(str_done) |=> lat_b); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> lat_a || lat_b); // R8
endmodule

bind hs_flag_unit hs_flag_unit_chk u_chk (.*);

// File: tb/test_hs_flag_unit.sv
module test_hs_flag_unit;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_addr = 0, loop_mode = 0, peer_req_a = 0, peer_req_b = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0, peer_din = 16'h1234;
  logic [15:0] rd_data, link_data;
  logic str_ready, str_done, irq;

  hs_flag_unit i_hs_flag_unit (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .loop_mode, .peer_req_a, .peer_req_b, .peer_din, .link_data, .str_ready, .str_done, .irq);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit run = 0;

  // behavioural reference
  bit m_rdy, m_dn, m_ea, m_eb, m_raise, m_pulse, m_la, m_lb, m_pr, m_pd;
  bit so_r, so_d, e_a, e_b, c_a, c_b;
  bit ha[3], hb[3];
  logic [15:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_rdy, m_dn, m_ea, m_eb, m_raise, m_pulse, m_la, m_lb, m_pr, m_pd} = '0;
      ha = '{0, 0, 0}; hb = '{0, 0, 0}; m_data = 0;
    end else begin
      so_r = m_rdy; so_d = m_dn | m_pulse;
      e_a = loop_mode ? (so_r && !m_pr) : (ha[1] && !ha[2]);
      e_b = loop_mode ? (so_d && !m_pd) : (hb[1] && !hb[2]);
      c_a = wr_en && (wr_addr == 0 || wr_addr == 2 || wr_addr == 4);
      c_b = wr_en && (wr_addr == 0 || wr_addr == 1 || wr_addr == 3);
      m_pr = so_r; m_pd = so_d;
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = peer_req_a;
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = peer_req_b;
      m_pulse = 0;
      if (m_raise) begin m_rdy = 1; m_raise = 0; end
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_rdy = wr_data[0]; m_dn = wr_data[1]; m_ea = wr_data[4]; m_eb = wr_data[5]; m_raise = 0;
        end else if (wr_addr == 1) begin
          m_data = wr_data; m_rdy = 0; m_raise = 1;
        end else if (wr_addr == 2) m_pulse = 1;
      end
      m_la = e_a || (m_la && !c_a);
      m_lb = e_b || (m_lb && !c_b);
    end
  end

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    cmp("link_data", link_data, m_data);
    cmp("str_ready", 16'(str_ready), 16'(m_rdy));
    cmp("str_done", 16'(str_done), 16'(m_dn | m_pulse));
    cmp("irq", 16'(irq), 16'((m_la & m_ea) | (m_lb & m_eb)));
    cmp("rd_data", rd_data, rd_addr ? peer_din : {8'h0, m_lb, m_la, m_eb, m_ea, 2'b00, m_dn, m_rdy});
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    step; wr_en = 1; wr_addr = a; wr_data = d;
    step; wr_en = 0;
  endtask

  initial begin
    step(3); rst_n = 1; run = 1;
    @(negedge clk);
    tag = "R1";
    cmp("R1 reset read", rd_data, 16'h0);
    cmp("R1 reset strobes", 16'({str_ready, str_done, irq}), 16'h0);
    step(2);
    tag = "R2"; wr(0, 16'hFFFF); step(2);          // R2: bits 2,3 read zero
    @(negedge clk); cmp("R2 ctrl read", rd_data, 16'h0033);
    tag = "R6"; step; peer_req_a = 1; step(5);     // R6 peer edge sets latch A
    @(negedge clk); cmp("R6 latch A", 16'(rd_data[6]), 16'h1);
    tag = "R5"; wr(4, 0); step(4);                 // R5 clear A, level still high
    tag = "R6"; peer_req_b = 1; step(5); peer_req_a = 0; peer_req_b = 0; step(3);
    tag = "R5"; wr(3, 0); step(2);
    tag = "R3"; step; peer_req_b = 1; step(5); peer_req_b = 0;
    wr(1, 16'hA5C3); step(3);                      // R3 send clears B
    @(negedge clk); cmp("R3 data", link_data, 16'hA5C3);
    tag = "R4"; wr(0, 16'h0031); step(2); wr(2, 0); step(3);   // R4 take pulse
    tag = "R8"; step; peer_req_a = 1; peer_req_b = 1; step(5);
    wr(0, 16'h0000); step; peer_req_a = 0; peer_req_b = 0; step(3);
    peer_req_a = 1; step(5); peer_req_a = 0; step(3);           // R8 latch with enable off
    @(negedge clk); cmp("R8 irq masked", 16'(irq), 16'h0);
    wr(0, 16'h0010); step(2); peer_req_a = 1; step(5); peer_req_a = 0; step(2);
    tag = "R7"; loop_mode = 1; wr(0, 16'h0030); step(2);
    wr(2, 0); step(3);                              // R7 loop done -> latch B
    @(negedge clk); cmp("R7 loop B", 16'(rd_data[7]), 16'h1);
    wr(1, 16'h5AA5); step(4);                       // R7 loop ready -> latch A
    wr(4, 0); wr(3, 0);
    peer_req_a = 1; peer_req_b = 1; step(6); peer_req_a = 0; peer_req_b = 0; step(2);
    @(negedge clk); cmp("R7 peer ignored", 16'(rd_data[7:6]), 16'h0);
    tag = "R9"; step; wr_en = 1; wr_addr = 2; step; wr_addr = 3; step; wr_en = 0; step(2);
    @(negedge clk); cmp("R9 set wins", 16'(rd_data[7]), 16'h1);
    tag = "R10"; wr(6, 16'hFFFF); wr(5, 16'hFFFF); wr(7, 16'hFFFF); step(2);
    rd_addr = 1; peer_din = 16'hBEEF; step(2);
    @(negedge clk); cmp("R10 peer read", rd_data, 16'hBEEF);
    rd_addr = 0; loop_mode = 0; step(3);
    run = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule